// File: doc/BRIEF.md
# FIFO Service Request and Interrupt Controller

This block sits between a host-facing pair of FIFOs (one carrying data in, one carrying data out) and an internal CPU. It keeps an 8-bit control register that the CPU writes and reads back. From the FIFO flags, the error strobes and the immediate-command register events, it produces two per-channel service requests (for a DMA engine or for software) and a single CPU interrupt request.

Every interrupt source latches into its own sticky pending flag. The CPU sees the pending vector and clears flags by writing ones on an acknowledge input. The interrupt output is the OR of the pending flags whose group enable is set. The trigger point of each channel's service request can be chosen: either as soon as work exists, or only at the FIFO's boundary. A channel that is handed to DMA keeps driving its service request but never posts a request-for-service interrupt. While the freeze control bit is clear, the freeze output is high and both service requests are held low.

Top module: `fsi_irq_ctrl`

## Requirements
- R1: After reset the control register reads 8'h04, freeze is 1, irq is 0, both service requests are 0 and the pending vector is 0.
- R2: The control register bit layout is [7] input interrupt enable, [6] output interrupt enable, [5] command-in interrupt enable, [4] command-out interrupt enable, [3] run (1 = normal, 0 = freeze), [2] reserved, [1] input trigger mode, [0] output trigger mode. A write takes effect on the clock edge where ctrl_we is high. Bit 2 always reads 1, whatever value is written.
- R3: With bit 1 = 1, in_svc_req is high when the input FIFO is not empty. With bit 1 = 0, it is high only when the input FIFO is full. The output is registered: it follows a flag change one clock later.
- R4: With bit 0 = 1, out_svc_req is high when the output FIFO is not full. With bit 0 = 0, it is high only when the output FIFO is empty. It is registered in the same way as in_svc_req.
- R5: While bit 3 = 0, freeze is 1, both service requests are 0 and no request-for-service pending flag is set.
- R6: Each pending bit is set by its event and stays set until it is acknowledged. The pending bits are: [0] input underrun, [1] data-stream command, [2] input request-for-service, [3] output overrun, [4] output request-for-service, [5] command-in written, [6] command-out became available (rising edge only). A pending bit is visible one clock after its event.
- R7: irq is high when any pending bit is high and its group is enabled. Pending bits 0 to 2 use control bit 7, bits 3 to 4 use bit 6, bit 5 uses bit 5, and bit 6 uses bit 4.
- R8: When a channel's DMA enable input is high, its request-for-service condition does not set its pending bit (bit 2 for input, bit 4 for output), but its service request still asserts.
- R9: An acknowledge with ack_we high clears exactly the pending bits whose ack_mask bit is 1. If a new event for a bit arrives in the same cycle as its acknowledge, the bit stays set.
- R10: Holding cmd_out_avail high does not set pending bit 6 again after it has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| ack_we | input | 1 | Pending acknowledge strobe |
| ack_mask | input | 7 | Pending bits to clear (write one to clear) |
| pend_o | output | 7 | Pending interrupt flags |
| in_empty | input | 1 | Input FIFO empty |
| in_full | input | 1 | Input FIFO full |
| out_empty | input | 1 | Output FIFO empty |
| out_full | input | 1 | Output FIFO full |
| in_underrun | input | 1 | Input underrun error strobe |
| out_overrun | input | 1 | Output overrun error strobe |
| dstream_cmd | input | 1 | Data-stream command strobe |
| cmd_in_wr | input | 1 | Immediate command-in written strobe |
| cmd_out_avail | input | 1 | Immediate command-out register available |
| in_dma_en | input | 1 | Input channel is serviced by DMA |
| out_dma_en | input | 1 | Output channel is serviced by DMA |
| irq | output | 1 | CPU interrupt request |
| in_svc_req | output | 1 | Input channel service request |
| out_svc_req | output | 1 | Output channel service request |
| freeze | output | 1 | FIFO/DMA freeze mode active |

## Verification
An event for a pending bit and the CPU's acknowledge of that same bit can land in one clock cycle. The bench provokes this by driving cmd_in_wr together with an acknowledge mask that holds bit 5. It expects the bit to remain set afterwards, and expects a later acknowledge on its own to clear it. It also acknowledges one bit while a different bit is pending, and checks that the other bit is left untouched.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int CTRL_W = 8;
  localparam int NSRC   = 7;

  localparam int B_IN_IE    = 7;
  localparam int B_OUT_IE   = 6;
  localparam int B_CI_IE    = 5;
  localparam int B_CO_IE    = 4;
  localparam int B_RUN      = 3;
  localparam int B_RSVD     = 2;
  localparam int B_IN_MODE  = 1;
  localparam int B_OUT_MODE = 0;

  localparam int S_IN_UNDER = 0;
  localparam int S_IN_DSC   = 1;
  localparam int S_IN_RFS   = 2;
  localparam int S_OUT_OVER = 3;
  localparam int S_OUT_RFS  = 4;
  localparam int S_CMD_IN   = 5;
  localparam int S_CMD_OUT  = 6;

  localparam logic [CTRL_W-1:0] CTRL_RST  = '0;
  localparam logic [CTRL_W-1:0] RSVD_ONE  = CTRL_W'(1) << B_RSVD;
  localparam logic [CTRL_W-1:0] CTRL_WMSK = ~RSVD_ONE;

  // service trigger condition for one channel
  function automatic logic svc_cond(input logic is_out, input logic mode,
                                    input logic empty, input logic full);
    if (!is_out) return mode ? ~empty : full;
    else         return mode ? ~full  : empty;
  endfunction

  // per-source enable derived from the control register
  function automatic logic [NSRC-1:0] src_en(input logic [CTRL_W-1:0] c);
    logic [NSRC-1:0] e;
    e             = '0;
    e[S_IN_UNDER] = c[B_IN_IE];
    e[S_IN_DSC]   = c[B_IN_IE];
    e[S_IN_RFS]   = c[B_IN_IE];
    e[S_OUT_OVER] = c[B_OUT_IE];
    e[S_OUT_RFS]  = c[B_OUT_IE];
    e[S_CMD_IN]   = c[B_CI_IE];
    e[S_CMD_OUT]  = c[B_CO_IE];
    return e;
  endfunction
endpackage

// File: rtl/fsi_ctrl_reg.sv
module fsi_ctrl_reg
  import fsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= CTRL_RST;
    else if (we) ctrl_q <= wdata & CTRL_WMSK;
  end

  assign rdata = ctrl_q | RSVD_ONE;
endmodule

// File: rtl/fsi_svc_chan.sv
module fsi_svc_chan
  import fsi_pkg::*;
#(
  parameter bit IS_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic empty,
  input  logic full,
  input  logic run,
  input  logic dma_en,
  output logic req,
  output logic rfs_ev
);
  logic cond;
  logic req_q;

  generate
    if (IS_OUT) begin : g_out
      assign cond = svc_cond(1'b1, mode, empty, full);
    end else begin : g_in
      assign cond = svc_cond(1'b0, mode, empty, full);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= cond;
  end

  assign req    = req_q & run;
  assign rfs_ev = cond & run & ~dma_en;
endmodule

// File: rtl/fsi_pend.sv
module fsi_pend
  import fsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic            ack_we,
  input  logic [NSRC-1:0] ack_mask,
  output logic [NSRC-1:0] pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pend[i] <= 1'b0;
      else if (set_ev[i])              pend[i] <= 1'b1;
      else if (ack_we && ack_mask[i])  pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsi_irq_ctrl.sv
module fsi_irq_ctrl
  import fsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              ack_we,
  input  logic [NSRC-1:0]   ack_mask,
  output logic [NSRC-1:0]   pend_o,
  input  logic              in_empty,
  input  logic              in_full,
  input  logic              out_empty,
  input  logic              out_full,
  input  logic              in_underrun,
  input  logic              out_overrun,
  input  logic              dstream_cmd,
  input  logic              cmd_in_wr,
  input  logic              cmd_out_avail,
  input  logic              in_dma_en,
  input  logic              out_dma_en,
  output logic              irq,
  output logic              in_svc_req,
  output logic              out_svc_req,
  output logic              freeze
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              run;
  logic              in_rfs_ev, out_rfs_ev;
  logic              co_avail_q, co_rise;
  logic [NSRC-1:0]   ev_set;

  fsi_ctrl_reg u_reg (
    .clk, .rst_n, .we(ctrl_we), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .rdata(ctrl_rdata)
  );

  assign run    = ctrl_q[B_RUN];
  assign freeze = ~run;

  fsi_svc_chan #(.IS_OUT(1'b0)) u_in (
    .clk, .rst_n, .mode(ctrl_q[B_IN_MODE]), .empty(in_empty), .full(in_full),
    .run(run), .dma_en(in_dma_en), .req(in_svc_req), .rfs_ev(in_rfs_ev)
  );

  fsi_svc_chan #(.IS_OUT(1'b1)) u_out (
    .clk, .rst_n, .mode(ctrl_q[B_OUT_MODE]), .empty(out_empty), .full(out_full),
    .run(run), .dma_en(out_dma_en), .req(out_svc_req), .rfs_ev(out_rfs_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) co_avail_q <= 1'b0;
    else        co_avail_q <= cmd_out_avail;
  end
  assign co_rise = cmd_out_avail & ~co_avail_q;

  always_comb begin
    ev_set             = '0;
    ev_set[S_IN_UNDER] = in_underrun;
    ev_set[S_IN_DSC]   = dstream_cmd;
    ev_set[S_IN_RFS]   = in_rfs_ev;
    ev_set[S_OUT_OVER] = out_overrun;
    ev_set[S_OUT_RFS]  = out_rfs_ev;
    ev_set[S_CMD_IN]   = cmd_in_wr;
    ev_set[S_CMD_OUT]  = co_rise;
  end

  fsi_pend u_pend (
    .clk, .rst_n, .set_ev(ev_set), .ack_we(ack_we), .ack_mask(ack_mask),
    .pend(pend_o)
  );

  assign irq = |(pend_o & src_en(ctrl_q));
endmodule

// File: rtl/fsi_irq_ctrl_chk.sv
module fsi_irq_ctrl_chk
  import fsi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ack_we,
  input logic            cmd_in_wr,
  input logic            in_dma_en,
  input logic            out_dma_en,
  input logic [NSRC-1:0] pend_o,
  input logic [NSRC-1:0] ev_set,
  input logic            irq,
  input logic            freeze,
  input logic            in_svc_req,
  input logic            out_svc_req
);
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!in_svc_req && !out_svc_req)); // R5
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_o != '0)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R6
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((pend_o & $past(ev_set)) == $past(ev_set))); // R9
  AST_CMD_IN_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_in_wr |=> pend_o[S_CMD_IN]); // R6
  AST_IN_DMA_NO_RFS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[S_IN_RFS]) |-> !$past(in_dma_en)); // R8
  AST_OUT_DMA_NO_RFS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[S_OUT_RFS]) |-> !$past(out_dma_en)); // R8
endmodule

bind fsi_irq_ctrl fsi_irq_ctrl_chk u_chk (.*);

// File: tb/tb_fsi_irq_ctrl.sv
module tb_fsi_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       ack_we = 1'b0;
  logic [6:0] ack_mask = '0;
  logic [6:0] pend_o;
  logic in_empty = 1'b1, in_full = 1'b0, out_empty = 1'b0, out_full = 1'b1;
  logic in_underrun = 1'b0, out_overrun = 1'b0, dstream_cmd = 1'b0;
  logic cmd_in_wr = 1'b0, cmd_out_avail = 1'b0;
  logic in_dma_en = 1'b1, out_dma_en = 1'b1;
  logic irq, in_svc_req, out_svc_req, freeze;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsi_irq_ctrl dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIL%s %s: actual %h expected %h", "", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    tick();
    ctrl_we = 1'b0;
  endtask

  task automatic ack(input logic [6:0] m);
    ack_we = 1'b1; ack_mask = m;
    tick();
    ack_we = 1'b0; ack_mask = '0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl_rdata", ctrl_rdata, 8'h04);
    chk("R1 freeze", {7'd0, freeze}, 8'd1);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 svc", {6'd0, in_svc_req, out_svc_req}, 8'd0);
    chk("R1 pend", {1'b0, pend_o}, 8'd0);
  endtask

  task automatic t_regs();
    wr_ctrl(8'hFB);
    chk("R2 readback all ones", ctrl_rdata, 8'hFF);
    wr_ctrl(8'h00);
    chk("R2 reserved reads one", ctrl_rdata, 8'h04);
    wr_ctrl(8'h5A);
    chk("R2 pattern", ctrl_rdata, 8'h5E);
  endtask

  task automatic t_in_mode();
    wr_ctrl(8'h08);
    in_empty = 1'b0; in_full = 1'b0;
    tick();
    chk("R3 mode0 partial", {7'd0, in_svc_req}, 8'd0);
    in_full = 1'b1;
    #1;
    chk("R3 registered latency", {7'd0, in_svc_req}, 8'd0);
    tick();
    chk("R3 mode0 full", {7'd0, in_svc_req}, 8'd1);
    in_full = 1'b0;
    wr_ctrl(8'h0A);
    tick();
    chk("R3 mode1 not empty", {7'd0, in_svc_req}, 8'd1);
    in_empty = 1'b1;
    tick();
    chk("R3 mode1 empty", {7'd0, in_svc_req}, 8'd0);
  endtask

  task automatic t_out_mode();
    wr_ctrl(8'h08);
    out_full = 1'b0; out_empty = 1'b1;
    tick();
    chk("R4 mode0 empty", {7'd0, out_svc_req}, 8'd1);
    out_empty = 1'b0;
    tick();
    chk("R4 mode0 partial", {7'd0, out_svc_req}, 8'd0);
    wr_ctrl(8'h09);
    tick();
    chk("R4 mode1 not full", {7'd0, out_svc_req}, 8'd1);
    out_full = 1'b1;
    tick();
    chk("R4 mode1 full", {7'd0, out_svc_req}, 8'd0);
  endtask

  task automatic t_dma();
    ack(7'h7F);
    in_dma_en = 1'b0;
    wr_ctrl(8'h8A);
    in_empty = 1'b0;
    tick();
    chk("R8 in rfs pend", {1'b0, pend_o}, 8'h04);
    chk("R7 in irq", {7'd0, irq}, 8'd1);
    in_dma_en = 1'b1;
    ack(7'h04);
    chk("R8 in dma no pend", {1'b0, pend_o}, 8'h00);
    chk("R8 in dma req", {7'd0, in_svc_req}, 8'd1);
    out_dma_en = 1'b0;
    wr_ctrl(8'h49);
    out_full = 1'b0;
    tick();
    chk("R8 out rfs pend", {1'b0, pend_o}, 8'h10);
    chk("R7 out irq", {7'd0, irq}, 8'd1);
    out_dma_en = 1'b1;
    ack(7'h10);
    chk("R8 out dma no pend", {1'b0, pend_o}, 8'h00);
    chk("R8 out dma req", {7'd0, out_svc_req}, 8'd1);
  endtask

  task automatic t_freeze();
    wr_ctrl(8'h0B);
    tick();
    chk("R5 running reqs", {6'd0, in_svc_req, out_svc_req}, 8'h03);
    wr_ctrl(8'h03);
    chk("R5 freeze out", {7'd0, freeze}, 8'd1);
    chk("R5 reqs low", {6'd0, in_svc_req, out_svc_req}, 8'h00);
    in_dma_en = 1'b0; out_dma_en = 1'b0;
    ack(7'h7F);
    tick();
    chk("R5 no rfs pend", {1'b0, pend_o}, 8'h00);
    in_dma_en = 1'b1; out_dma_en = 1'b1;
    in_empty = 1'b1; out_full = 1'b1;
  endtask

  task automatic t_events();
    wr_ctrl(8'h00);
    ack(7'h7F);
    in_underrun = 1'b1; tick(); in_underrun = 1'b0;
    chk("R6 underrun pend", {1'b0, pend_o}, 8'h01);
    chk("R7 irq masked", {7'd0, irq}, 8'd0);
    tick();
    chk("R6 sticky", {1'b0, pend_o}, 8'h01);
    wr_ctrl(8'h80);
    chk("R7 irq in group", {7'd0, irq}, 8'd1);
    ack(7'h01);
    chk("R9 ack clears", {6'd0, irq, |pend_o}, 8'd0);
    dstream_cmd = 1'b1; tick(); dstream_cmd = 1'b0;
    chk("R6 dstream pend", {1'b0, pend_o}, 8'h02);
    ack(7'h02);
    out_overrun = 1'b1; tick(); out_overrun = 1'b0;
    chk("R6 overrun pend", {1'b0, pend_o}, 8'h08);
    chk("R7 wrong group", {7'd0, irq}, 8'd0);
    wr_ctrl(8'h40);
    chk("R7 out group", {7'd0, irq}, 8'd1);
    ack(7'h08);
    cmd_in_wr = 1'b1; tick(); cmd_in_wr = 1'b0;
    chk("R6 cmd in pend", {1'b0, pend_o}, 8'h20);
    chk("R7 cmd in masked", {7'd0, irq}, 8'd0);
    wr_ctrl(8'h20);
    chk("R7 cmd in irq", {7'd0, irq}, 8'd1);
    ack(7'h20);
    wr_ctrl(8'h10);
    cmd_out_avail = 1'b1; tick();
    chk("R6 cmd out pend", {1'b0, pend_o}, 8'h40);
    chk("R7 cmd out irq", {7'd0, irq}, 8'd1);
    ack(7'h40);
    tick(); tick();
    chk("R10 level held no repend", {1'b0, pend_o}, 8'h00);
    cmd_out_avail = 1'b0;
    tick();
  endtask

  task automatic t_collide();
    wr_ctrl(8'h20);
    cmd_in_wr = 1'b1; ack_we = 1'b1; ack_mask = 7'h20;
    tick();
    cmd_in_wr = 1'b0; ack_we = 1'b0; ack_mask = '0;
    chk("R9 set wins", {1'b0, pend_o}, 8'h20);
    chk("R9 irq kept", {7'd0, irq}, 8'd1);
    in_underrun = 1'b1; tick(); in_underrun = 1'b0;
    ack(7'h20);
    chk("R9 selective clear", {1'b0, pend_o}, 8'h01);
    ack(7'h01);
    chk("R9 all clear", {1'b0, pend_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_in_mode();
    t_out_mode();
    t_dma();
    t_freeze();
    t_events();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule